// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog timer with a small register interface: a command word, a mode word and a status word. A 12-bit down-counter advances once per 128 ticks of a slow time base. Software keeps the system alive by writing a keyed restart command. A restart that comes while the counter is still above a programmed window value counts as premature, and the block flags it as a fault. A counter that runs out also raises a fault. Either event can drive a level interrupt and a one-cycle reset request. Each output has its own enable.

Counting can be frozen while the processor sits in a debug halt or in idle. Each of the two freezes is selected separately. The reload and window fields only change while the timer is enabled, and any mode write made while enabled reloads the counter. Writes to the command or mode word that follow the previous accepted one too closely are dropped. The reset controller that consumes the reset request is outside this block, and so is the bus fabric.

Top module: `wdog_timer`

## Requirements
- R1: After reset the timer is disabled, with reload 0xFFF and window 0xFFF, so the mode word reads 0x0FFF8FFF. Status reads 0, the command word reads 0, and `irq` and `rst_req` are low.
- R2: A write to the command word (`bus_addr`=0) restarts the counter from the reload value only if bits 31:24 are 0xA5, bit 0 is 1 and bits 23:1 are 0. Any other command write is ignored.
- R3: While enabled, the counter loses one step every 128 `slow_tick` pulses. From a restart at reload R, the counter runs out after 128*(R+1) ticks. It then sets status bit 0 (underflow) and reloads, so it repeats with the same period.
- R4: `irq` is high while status bit 0 or bit 1 is set and mode bit 12 is set. It is low whenever mode bit 12 is clear.
- R5: When mode bit 13 is set, each underflow or window error drives `rst_req` high for exactly one clock.
- R6: A valid restart while the counter is above the window field (mode bits 27:16) sets status bit 1 (error) and leaves the count running undisturbed. A valid restart at or below the window reloads without error.
- R7: Reading the status word (`bus_addr`=2) returns {error, underflow} in bits 1:0 and clears both flags.
- R8: While mode bit 15 is set, the counter holds, no flag is raised, `rst_req` stays low and restarts are ignored.
- R9: A mode write (`bus_addr`=1) made while disabled updates only bits 12, 13, 15, 28 and 29, and enabling reloads the counter from the stored reload. A mode write made while enabled also updates reload (bits 11:0) and window (bits 27:16) and restarts the counter.
- R10: A command or mode write is ignored if fewer than 3 `slow_tick` pulses have passed since the previous accepted one.
- R11: With mode bit 28 set, `dbg_halt` freezes counting. With mode bit 29 set, `idle_halt` freezes counting. A halt input whose mode bit is clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle pulse per slow time-base period |
| dbg_halt | input | 1 | Processor is in debug halt |
| idle_halt | input | 1 | Processor is idle |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Word index: 0 command, 1 mode, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Fault interrupt, level |
| rst_req | output | 1 | Reset request, one-cycle pulse |

## Verification
The countdown is measured edge-exact from the restarting write to the reset pulse. This is done for a mode-write restart, for a free-running repeat, and for a keyed restart placed mid-period, so that off-by-one faults in the prescaler or the reload show up as a shifted interval. Malformed commands (wrong key, restart bit clear, reserved bit set) and commands inside the guard interval must leave that interval unchanged, which separates "ignored" from "accepted". Restarts above and at the window value show the error path (pulse now, count undisturbed) against the legal path (reload, no pulse). Freeze inputs held for a known number of cycles must stretch the period by exactly that amount when their mode bit is set, and must not stretch it when the bit is clear.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int PRESCALE = 128,
  parameter int CNT_W    = 12,
  parameter int GAP_MIN  = 3,
  parameter logic [7:0] KEY = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_tick,
  input  logic        dbg_halt,
  input  logic        idle_halt,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        rst_req
);
  localparam int PRE_W = $clog2(PRESCALE);
  localparam int GAP_W = $clog2(GAP_MIN + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [GAP_W-1:0] GAP_FULL = GAP_W'(GAP_MIN);

  logic [CNT_W-1:0] reload_q, window_q, cnt_q;
  logic             fien_q, rsten_q, dis_q, dbgh_q, idleh_q;
  logic [PRE_W-1:0] pre_q;
  logic [GAP_W-1:0] gap_q;
  logic             unf_q, err_q, rst_q;

  wire en       = !dis_q;
  wire wr_ctrl  = bus_sel && bus_wr && bus_addr == 2'd0;
  wire wr_mode  = bus_sel && bus_wr && bus_addr == 2'd1;
  wire rd_stat  = bus_sel && !bus_wr && bus_addr == 2'd2;
  wire gap_ok   = gap_q == GAP_FULL;
  wire acc_ctrl = wr_ctrl && gap_ok;
  wire acc_mode = wr_mode && gap_ok;

  wire cmd_ok   = bus_wdata[31:24] == KEY && bus_wdata[0] && bus_wdata[23:1] == 23'd0;
  wire kick     = acc_ctrl && cmd_ok && en;
  wire early    = kick && (cnt_q > window_q);
  wire good     = kick && !early;

  wire new_en   = !bus_wdata[15];
  wire mode_ld  = acc_mode && (en || new_en);
  wire halted   = (dbg_halt && dbgh_q) || (idle_halt && idleh_q);
  wire run      = en && slow_tick && !halted;
  wire step     = run && pre_q == PRE_LAST;
  wire underflw = step && cnt_q == '0 && !acc_mode && !good;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '1;
      window_q <= '1;
      fien_q   <= 1'b0;
      rsten_q  <= 1'b0;
      dis_q    <= 1'b1;
      dbgh_q   <= 1'b0;
      idleh_q  <= 1'b0;
    end else if (acc_mode) begin
      fien_q  <= bus_wdata[12];
      rsten_q <= bus_wdata[13];
      dis_q   <= bus_wdata[15];
      dbgh_q  <= bus_wdata[28];
      idleh_q <= bus_wdata[29];
      if (en) begin
        reload_q <= bus_wdata[CNT_W-1:0];
        window_q <= bus_wdata[16 +: CNT_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      pre_q <= '0;
    end else if (mode_ld) begin
      cnt_q <= en ? bus_wdata[CNT_W-1:0] : reload_q;
      pre_q <= '0;
    end else if (good) begin
      cnt_q <= reload_q;
      pre_q <= '0;
    end else if (run) begin
      pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
      if (step)
        cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      gap_q <= GAP_FULL;
    else if (acc_ctrl || acc_mode)
      gap_q <= '0;
    else if (slow_tick && !gap_ok)
      gap_q <= gap_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unf_q <= 1'b0;
      err_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      unf_q <= underflw || (unf_q && !rd_stat);
      err_q <= early || (err_q && !rd_stat);
      rst_q <= rsten_q && (underflw || early);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        2'd1: begin
          bus_rdata[CNT_W-1:0]    = reload_q;
          bus_rdata[16 +: CNT_W]  = window_q;
          bus_rdata[12]           = fien_q;
          bus_rdata[13]           = rsten_q;
          bus_rdata[15]           = dis_q;
          bus_rdata[28]           = dbgh_q;
          bus_rdata[29]           = idleh_q;
        end
        2'd2: bus_rdata[1:0] = {err_q, unf_q};
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq     = fien_q && (unf_q || err_q);
  assign rst_req = rst_q;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dis_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] reload_q,
  input logic             unf_q,
  input logic             err_q,
  input logic             rst_req
);
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  a_r5_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (unf_q || err_q));

  a_r8_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_q && $past(dis_q)) |-> $stable(cnt_q));

  a_r8_no_new_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_q && $past(dis_q)) |-> (!$rose(unf_q) && !$rose(err_q)));

  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    !dis_q |-> cnt_q <= reload_q);
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dis_q(dis_q), .cnt_q(cnt_q),
  .reload_q(reload_q), .unf_q(unf_q), .err_q(err_q), .rst_req(rst_req)
);

// File: tb/test_wdog_timer.sv
`timescale 1ns/1ps
module test_wdog_timer;
  logic clk = 0, rst_n = 0;
  logic slow_tick = 1, dbg_halt = 0, idle_halt = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq, rst_req;

  int checks = 0, fails = 0, cyc = 0, last_wr = 0, pulses = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && rst_req) pulses <= pulses + 1;

  wdog_timer i_wdog_timer (.*);

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && bus_sel && !bus_wr) begin
      if (exp_q.size() == 0) check("scoreboard", 1, 0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = 0;
    last_wr = cyc;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string req);
    exp_q.push_back(e); tag_q.push_back(req);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic wait_pulse(output int t);
    int n = 0;
    do begin @(negedge clk); n++; end while (!rst_req && n < 5000);
    t = cyc;
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int t, t2, em, ek;
    idle(3); rst_n = 1; idle(2);
    // R1 reset state
    check("R1 irq", irq, 0); check("R1 rst_req", rst_req, 0);
    rd(1, 32'h0FFF8FFF, "R1 mode");
    rd(2, 0, "R1 status");
    rd(0, 0, "R1 command");
    // R8 disabled: restart ignored, nothing happens
    wr(0, 32'hA5000001); idle(300);
    check("R8 no pulse", pulses, 0);
    rd(2, 0, "R8 status");
    // R9 write while disabled keeps reload/window
    wr(1, 32'h00003005); idle(8);
    rd(1, 32'h0FFF3FFF, "R9 fields kept");
    // R3/R5 period from mode-write restart
    wr(1, 32'h0FFF3003); em = last_wr;
    wait_pulse(t);
    check("R3 period", t - em, 512);
    check("R4 irq set", irq, 1);
    idle(1); check("R5 one cycle", rst_req, 0);
    rd(2, 1, "R7 underflow");
    check("R7 irq cleared", irq, 0);
    rd(2, 0, "R7 cleared");
    wait_pulse(t2);
    check("R3 repeat", t2 - t, 512);
    // R2 malformed commands ignored
    idle(100);
    wr(0, 32'h5A000001); idle(8);
    wr(0, 32'hA5000000); idle(8);
    wr(0, 32'hA5000003);
    wait_pulse(t);
    check("R2 bad cmds ignored", t - t2, 512);
    idle(50);
    wr(0, 32'hA5000001); ek = last_wr;
    wait_pulse(t);
    check("R2 keyed restart", t - ek, 512);
    rd(2, 1, "R7 status");
    // R6 window
    idle(8);
    wr(1, 32'h00023007); em = last_wr; idle(10);
    wr(0, 32'hA5000001);
    check("R6 early pulse", rst_req, 1);
    check("R4 irq on error", irq, 1);
    rd(2, 2, "R6 error flag");
    while (cyc < em + 660) @(negedge clk);
    wr(0, 32'hA5000001); ek = last_wr;
    check("R6 legal no pulse", rst_req, 0);
    wait_pulse(t);
    check("R6 count undisturbed then reload", t - ek, 1024);
    rd(2, 1, "R6 no error on legal");
    // R11 halts
    idle(8);
    wr(1, 32'h10003003); em = last_wr;
    idle(100); dbg_halt = 1; idle(200); dbg_halt = 0;
    wait_pulse(t);
    check("R11 debug freeze", t - em, 712);
    idle(50); idle_halt = 1; idle(100); idle_halt = 0;
    wait_pulse(t2);
    check("R11 idle not selected", t2 - t, 512);
    rd(2, 1, "R11 status");
    // R10 guard, R4 irq disabled
    idle(8);
    wr(1, 32'h0FFF2003); em = last_wr;
    wr(0, 32'hA5000001);
    wr(1, 32'h0FFF3001);
    wait_pulse(t);
    check("R10 close writes ignored", t - em, 512);
    check("R4 irq masked", irq, 0);
    rd(1, 32'h0FFF2003, "R10 mode unchanged");
    rd(2, 1, "R10 status");
    // R8/R9 disable while enabled
    idle(8);
    wr(1, 32'h0FFFB003); t = pulses; idle(8);
    wr(0, 32'hA5000001); idle(1200);
    check("R8 held", pulses, t);
    rd(2, 0, "R8 no flags");
    rd(1, 32'h0FFFB003, "R9 enabled write");
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule